// File: doc/BRIEF.md
# Execute-Bit Wide-Word Sequencer

This block is the control core of a small serial processor driven by software. It fetches wide instruction words from an internal instruction memory and runs them. Each word holds four slots: an add unit, a subtract unit and two control slots. Every slot has its own enable bit and its own operand fields. All enabled data slots run together in one cycle, and at most one control slot may be enabled. The control slot can jump, branch on a comparison or halt.

A fixed rule decides which words may be grouped, and the sequencer checks it. A word that breaks the rule is not executed: it raises a sticky illegal flag and stops the core. While a word has no control operation, the fetch of the next word overlaps its execution. A control word costs extra cycles. A cycle counter and a halted output let a program's exact run time be measured. A read port on the register file exposes the results.

The instruction memory is loaded through a write port while reset is held. Reset is then released and the program runs until it halts.

Top module: `xbit_sequencer`

## Requirements
- R1: Bit positions, LSB first: add slot [10:0] = {imm[10], srcB[9:7], srcA[6:4], dst[3:1], en[0]}; sub slot [20:11] = {srcB[20:18], srcA[17:15], dst[14:12], en[11]}; control slot 0 [37:21] and control slot 1 [54:38], each {target[16:9], srcB[8:6], srcA[5:3], op[2:1], en[0]} relative to its base. Enabled add and sub slots execute in the same cycle, and both read register values from before the word.
- R2: The add unit writes srcA + srcB, or srcA + the zero-extended srcB field when imm is 1. The sub unit writes srcA - srcB. Both wrap modulo 2^16.
- R3: A word with both control slots enabled sets the sticky illegal output, writes no register and halts the core.
- R4: A word whose enabled control op is JEQ or JLT, and whose srcA or srcB equals the dst of an enabled data slot in the same word, is illegal (same effect as R3). JMP and HALT are exempt from this check.
- R5: A word whose add and sub slots are both enabled with the same dst is illegal (same effect as R3).
- R6: Data-slot writes in a word take effect even when that word's control op jumps or halts.
- R7: A word with no control slot enabled takes 1 cycle, because the next word is prefetched during execution.
- R8: A JMP word takes 2 cycles. A JEQ or JLT word takes 3 cycles (compare, jump, refetch), whether the branch is taken or not.
- R9: The op codes are 0 JMP, 1 JEQ (jump if srcA == srcB), 2 JLT (jump if srcA < srcB, unsigned) and 3 HALT. A jump goes to the 8-bit absolute target. A branch that is not taken continues at the next word.
- R10: The cycle counter rises by one in each cycle that the core is not halted. Once halted, the halted output stays high and the counter and PC hold their values.
- R11: Reset sets the PC, all registers and the counter to 0, and clears halted and illegal. One fetch cycle comes before the first word executes, so a program's cycle total is 1 plus the cost of its words, and the halting word costs 1.
- R12: The peek output shows register peek_sel one clock after it is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_we | input | 1 | Instruction memory write enable |
| imem_waddr | input | 8 | Instruction memory write address |
| imem_wdata | input | 55 | Instruction word to write |
| peek_sel | input | 3 | Register index to read out |
| peek_val | output | 16 | Registered value of the selected register |
| pc_o | output | 8 | Program counter |
| cycles | output | 16 | Cycles spent running since reset |
| halted | output | 1 | Core stopped (HALT or illegal word) |
| illegal | output | 1 | Sticky flag: a word broke the grouping rules |

## Verification
Straight-line programs of data-only words check concurrent execution, and in particular that a sub reads the value an add in the same word overwrites. Unsigned wrap and immediate operands are also covered, and the cycle totals separate the prefetch path from a refetch. Branch programs run JEQ and JLT both taken and not taken, including a value whose top bit is set, which tells an unsigned compare from a signed one. A counted loop checks that the branch costs add up over several iterations. Illegal words of each kind (two control slots, a conditional reading a register written in the same word, two writes to one register) are contrasted with an unconditional jump that names a written register, which must stay legal.

// File: rtl/xseq_pkg.sv
package xseq_pkg;

  typedef enum logic [1:0] {
    OP_JMP  = 2'd0,
    OP_JEQ  = 2'd1,
    OP_JLT  = 2'd2,
    OP_HALT = 2'd3
  } ctl_op_e;

  typedef enum logic [1:0] {
    S_FETCH = 2'd0,
    S_EXEC  = 2'd1,
    S_JUMP  = 2'd2,
    S_HALT  = 2'd3
  } seq_state_e;

endpackage

// File: rtl/xseq_imem.sv
module xseq_imem #(
  parameter int AW = 8,
  parameter int IW = 55,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [IW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [IW-1:0] rdata
);

  logic [IW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/xseq_regfile.sv
module xseq_regfile #(
  parameter int DW   = 16,
  parameter int NREG = 8,
  parameter int NRD  = 7,
  localparam int RIW = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we0,
  input  logic [RIW-1:0]     wa0,
  input  logic [DW-1:0]      wd0,
  input  logic               we1,
  input  logic [RIW-1:0]     wa1,
  input  logic [DW-1:0]      wd1,
  input  logic [NRD*RIW-1:0] raddr,
  output logic [NRD*DW-1:0]  rdata
);

  logic [DW-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      if (we0) regs[wa0] <= wd0;
      if (we1) regs[wa1] <= wd1;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata[g*DW +: DW] = regs[raddr[g*RIW +: RIW]];
  end

endmodule

// File: rtl/xseq_branch.sv
module xseq_branch
  import xseq_pkg::*;
#(
  parameter int DW = 16
) (
  input  ctl_op_e       op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic          take
);

  always_comb begin
    unique case (op)
      OP_JEQ:  take = (a == b);
      OP_JLT:  take = (a < b);
      OP_JMP:  take = 1'b1;
      default: take = 1'b0;
    endcase
  end

endmodule

// File: rtl/xbit_sequencer.sv
module xbit_sequencer
  import xseq_pkg::*;
#(
  parameter int DW   = 16,
  parameter int NREG = 8,
  parameter int AW   = 8,
  parameter int CW   = 16,
  localparam int RIW = $clog2(NREG),
  localparam int ASW = 3*RIW + 2,
  localparam int SSW = 3*RIW + 1,
  localparam int CSW = 3 + 2*RIW + AW,
  localparam int IW  = ASW + SSW + 2*CSW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           imem_we,
  input  logic [AW-1:0]  imem_waddr,
  input  logic [IW-1:0]  imem_wdata,
  input  logic [RIW-1:0] peek_sel,
  output logic [DW-1:0]  peek_val,
  output logic [AW-1:0]  pc_o,
  output logic [CW-1:0]  cycles,
  output logic           halted,
  output logic           illegal
);

  localparam int SB  = ASW;
  localparam int C0B = ASW + SSW;
  localparam int C1B = C0B + CSW;
  localparam int NRD = 7;

  seq_state_e    state;
  logic [AW-1:0] pc;
  logic [AW-1:0] rd_addr;
  logic [IW-1:0] ir;
  logic          take_q;
  logic [AW-1:0] tgt_q;

  // slot decode
  logic           a_en, a_imm, s_en, c0_en, c1_en;
  logic [RIW-1:0] a_dst, a_sa, a_sb, s_dst, s_sa, s_sb, c_sa, c_sb;
  logic [AW-1:0]  c_tgt;
  ctl_op_e        c_op;

  assign a_en  = ir[0];
  assign a_dst = ir[1 +: RIW];
  assign a_sa  = ir[1+RIW +: RIW];
  assign a_sb  = ir[1+2*RIW +: RIW];
  assign a_imm = ir[1+3*RIW];
  assign s_en  = ir[SB];
  assign s_dst = ir[SB+1 +: RIW];
  assign s_sa  = ir[SB+1+RIW +: RIW];
  assign s_sb  = ir[SB+1+2*RIW +: RIW];
  assign c0_en = ir[C0B];
  assign c1_en = ir[C1B];

  // the single control unit is fed by whichever slot is enabled
  always_comb begin
    if (c1_en) begin
      c_op  = ctl_op_e'(ir[C1B+1 +: 2]);
      c_sa  = ir[C1B+3 +: RIW];
      c_sb  = ir[C1B+3+RIW +: RIW];
      c_tgt = ir[C1B+3+2*RIW +: AW];
    end else begin
      c_op  = ctl_op_e'(ir[C0B+1 +: 2]);
      c_sa  = ir[C0B+3 +: RIW];
      c_sb  = ir[C0B+3+RIW +: RIW];
      c_tgt = ir[C0B+3+2*RIW +: AW];
    end
  end

  // grouping-rule checks
  logic ctl_any, ctl_two, ctl_cond, hz_add, hz_sub, dst_clash, bad_word;
  assign ctl_any   = c0_en | c1_en;
  assign ctl_two   = c0_en & c1_en;
  assign ctl_cond  = ctl_any & ((c_op == OP_JEQ) | (c_op == OP_JLT));
  assign hz_add    = a_en & ((a_dst == c_sa) | (a_dst == c_sb));
  assign hz_sub    = s_en & ((s_dst == c_sa) | (s_dst == c_sb));
  assign dst_clash = a_en & s_en & (a_dst == s_dst);
  assign bad_word  = ctl_two | (ctl_cond & (hz_add | hz_sub)) | dst_clash;

  logic in_exec, wr_add, wr_sub;
  assign in_exec = (state == S_EXEC);
  assign wr_add  = in_exec & a_en & ~bad_word;
  assign wr_sub  = in_exec & s_en & ~bad_word;

  // register file read ports: add A/B, sub A/B, control A/B, peek
  logic [NRD*RIW-1:0] rf_ra;
  logic [NRD*DW-1:0]  rf_rd;
  assign rf_ra = {peek_sel, c_sb, c_sa, s_sb, s_sa, a_sb, a_sa};

  logic [DW-1:0] v_aa, v_ab, v_sa, v_sb, v_ca, v_cb, v_pk, add_rhs, add_res, sub_res;
  assign v_aa = rf_rd[0*DW +: DW];
  assign v_ab = rf_rd[1*DW +: DW];
  assign v_sa = rf_rd[2*DW +: DW];
  assign v_sb = rf_rd[3*DW +: DW];
  assign v_ca = rf_rd[4*DW +: DW];
  assign v_cb = rf_rd[5*DW +: DW];
  assign v_pk = rf_rd[6*DW +: DW];

  assign add_rhs = a_imm ? DW'(a_sb) : v_ab;
  assign add_res = v_aa + add_rhs;
  assign sub_res = v_sa - v_sb;

  xseq_regfile #(.DW(DW), .NREG(NREG), .NRD(NRD)) u_rf (
    .clk   (clk),
    .rst   (rst),
    .we0   (wr_add),
    .wa0   (a_dst),
    .wd0   (add_res),
    .we1   (wr_sub),
    .wa1   (s_dst),
    .wd1   (sub_res),
    .raddr (rf_ra),
    .rdata (rf_rd)
  );

  logic br_take;
  xseq_branch #(.DW(DW)) u_br (
    .op   (c_op),
    .a    (v_ca),
    .b    (v_cb),
    .take (br_take)
  );

  // prefetch: while executing, read the word after the current one
  assign rd_addr = in_exec ? AW'(pc + 1'b1) : pc;

  xseq_imem #(.AW(AW), .IW(IW)) u_im (
    .clk   (clk),
    .we    (imem_we),
    .waddr (imem_waddr),
    .wdata (imem_wdata),
    .raddr (rd_addr),
    .rdata (ir)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_FETCH;
      pc      <= '0;
      cycles  <= '0;
      illegal <= 1'b0;
      take_q  <= 1'b0;
      tgt_q   <= '0;
    end else begin
      if (state != S_HALT) cycles <= cycles + 1'b1;
      unique case (state)
        S_FETCH: state <= S_EXEC;
        S_EXEC: begin
          if (bad_word) begin
            illegal <= 1'b1;
            state   <= S_HALT;
          end else if (!ctl_any) begin
            pc <= pc + 1'b1;
          end else begin
            unique case (c_op)
              OP_JMP: begin
                pc    <= c_tgt;
                state <= S_FETCH;
              end
              OP_HALT: state <= S_HALT;
              default: begin
                take_q <= br_take;
                tgt_q  <= c_tgt;
                state  <= S_JUMP;
              end
            endcase
          end
        end
        S_JUMP: begin
          pc    <= take_q ? tgt_q : AW'(pc + 1'b1);
          state <= S_FETCH;
        end
        default: state <= S_HALT;
      endcase
    end
  end

  always_ff @(posedge clk) peek_val <= v_pk;

  assign pc_o   = pc;
  assign halted = (state == S_HALT);

endmodule

// File: rtl/xseq_checker.sv
module xseq_checker #(
  parameter int AW = 8,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          halted,
  input logic          illegal,
  input logic [CW-1:0] cycles,
  input logic [AW-1:0] pc
);

  assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  assert_count_frozen_R10: assert property (@(posedge clk) disable iff (rst)
    halted |=> $stable(cycles));

  assert_pc_frozen_R10: assert property (@(posedge clk) disable iff (rst)
    halted |=> $stable(pc));

  assert_count_step_R10: assert property (@(posedge clk) disable iff (rst)
    !halted |=> (cycles == CW'($past(cycles) + 1'b1)));

  // R3, R4, R5: an illegal word always stops the core
  assert_illegal_halts_R3: assert property (@(posedge clk) disable iff (rst)
    illegal |-> halted);

  assert_illegal_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    illegal |=> illegal);

endmodule

bind xbit_sequencer xseq_checker #(.AW(AW), .CW(CW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .halted  (halted),
  .illegal (illegal),
  .cycles  (cycles),
  .pc      (pc_o)
);

// File: tb/sim_xbit_sequencer.sv
module sim_xbit_sequencer;

  localparam int IW = 55;
  localparam int NW = 6;
  localparam logic [IW-1:0] Z = '0;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          imem_we = 1'b0;
  logic [7:0]    imem_waddr = '0;
  logic [IW-1:0] imem_wdata = '0;
  logic [2:0]    peek_sel = '0;
  logic [15:0]   peek_val;
  logic [7:0]    pc_o;
  logic [15:0]   cycles;
  logic          halted, illegal;

  always #2 clk = ~clk;

  xbit_sequencer u0 (
    .clk(clk), .rst(rst), .imem_we(imem_we), .imem_waddr(imem_waddr),
    .imem_wdata(imem_wdata), .peek_sel(peek_sel), .peek_val(peek_val),
    .pc_o(pc_o), .cycles(cycles), .halted(halted), .illegal(illegal)
  );

  // slot builders following the R1 bit layout
  function automatic logic [10:0] ADD(input int d, input int a, input int b);
    return {1'b0, 3'(b), 3'(a), 3'(d), 1'b1};
  endfunction
  function automatic logic [10:0] ADDI(input int d, input int a, input int k);
    return {1'b1, 3'(k), 3'(a), 3'(d), 1'b1};
  endfunction
  function automatic logic [9:0] SUB(input int d, input int a, input int b);
    return {3'(b), 3'(a), 3'(d), 1'b1};
  endfunction
  // op codes per R9: 0 JMP, 1 JEQ, 2 JLT, 3 HALT
  function automatic logic [16:0] CTL(input int op, input int a, input int b, input int t);
    return {8'(t), 3'(b), 3'(a), 2'(op), 1'b1};
  endfunction
  function automatic logic [IW-1:0] W(input logic [10:0] a, input logic [9:0] s,
                                      input logic [16:0] c0, input logic [16:0] c1);
    return {c1, c0, s, a};
  endfunction
  function automatic logic [NW-1:0][IW-1:0] P(input logic [IW-1:0] w0, w1, w2, w3, w4, w5);
    logic [NW-1:0][IW-1:0] p;
    p[0] = w0; p[1] = w1; p[2] = w2; p[3] = w3; p[4] = w4; p[5] = w5;
    return p;
  endfunction

  localparam logic [IW-1:0] HW = {17'd0, 17'b00000000000000111, 10'd0, 11'd0};

  typedef struct packed {
    logic [NW-1:0][IW-1:0] prog;
    logic [15:0]           cyc;
    logic                  bad;
    logic [2:0]            ri;
    logic [15:0]           rv;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    // 0: R2 R7 R11 add immediate, straight line
    '{prog: P(W(ADDI(1,0,5),0,0,0), HW, Z, Z, Z, Z), cyc: 16'd3, bad: 1'b0, ri: 3'd1, rv: 16'd5},
    // 1: R1 sub reads r1 before the concurrent add overwrites it
    '{prog: P(W(ADDI(1,0,6),0,0,0), W(ADDI(1,1,1),SUB(2,1,0),0,0), HW, Z, Z, Z), cyc: 16'd4, bad: 1'b0, ri: 3'd2, rv: 16'd6},
    // 2: R1 the add of the same word still lands
    '{prog: P(W(ADDI(1,0,6),0,0,0), W(ADDI(1,1,1),SUB(2,1,0),0,0), HW, Z, Z, Z), cyc: 16'd4, bad: 1'b0, ri: 3'd1, rv: 16'd7},
    // 3: R2 subtract wraps
    '{prog: P(W(ADDI(1,0,1),0,0,0), W(0,SUB(2,0,1),0,0), HW, Z, Z, Z), cyc: 16'd4, bad: 1'b0, ri: 3'd2, rv: 16'hFFFF},
    // 4: R8 R6 JMP, data with HALT commits
    '{prog: P(W(0,0,CTL(0,0,0,3),0), W(ADDI(1,0,7),0,0,0), W(ADDI(1,0,7),0,0,0), W(ADDI(2,0,4),0,CTL(3,0,0,0),0), Z, Z), cyc: 16'd4, bad: 1'b0, ri: 3'd2, rv: 16'd4},
    // 5: R8 R9 JMP skips words
    '{prog: P(W(0,0,CTL(0,0,0,3),0), W(ADDI(1,0,7),0,0,0), W(ADDI(1,0,7),0,0,0), W(ADDI(2,0,4),0,CTL(3,0,0,0),0), Z, Z), cyc: 16'd4, bad: 1'b0, ri: 3'd1, rv: 16'd0},
    // 6: R9 JEQ taken
    '{prog: P(W(ADDI(1,0,2),0,0,0), W(0,0,CTL(1,0,0,3),0), W(ADDI(3,0,1),0,0,0), HW, Z, Z), cyc: 16'd6, bad: 1'b0, ri: 3'd3, rv: 16'd0},
    // 7: R9 R8 JEQ not taken still costs 3
    '{prog: P(W(ADDI(1,0,2),0,0,0), W(0,0,CTL(1,1,0,3),0), W(ADDI(3,0,1),0,0,0), HW, Z, Z), cyc: 16'd7, bad: 1'b0, ri: 3'd3, rv: 16'd1},
    // 8: R9 JLT unsigned: 2 < 0xFFFE taken
    '{prog: P(W(ADDI(1,0,2),0,0,0), W(0,SUB(2,0,1),0,0), W(0,0,CTL(2,1,2,4),0), W(ADDI(3,0,1),0,0,0), HW, Z), cyc: 16'd7, bad: 1'b0, ri: 3'd3, rv: 16'd0},
    // 9: R9 JLT unsigned: 0xFFFE < 2 not taken
    '{prog: P(W(ADDI(1,0,2),0,0,0), W(0,SUB(2,0,1),0,0), W(0,0,CTL(2,2,1,4),0), W(ADDI(3,0,1),0,0,0), HW, Z), cyc: 16'd8, bad: 1'b0, ri: 3'd3, rv: 16'd1},
    // 10: R8 counted loop, three passes
    '{prog: P(W(ADDI(1,0,3),0,0,0), W(ADDI(5,0,1),0,0,0), W(ADDI(6,6,1),SUB(1,1,5),0,0), W(0,0,CTL(2,0,1,2),0), HW, Z), cyc: 16'd16, bad: 1'b0, ri: 3'd6, rv: 16'd3},
    // 11: R3 two control slots
    '{prog: P(W(ADDI(1,0,5),0,0,0), W(ADDI(2,0,4),0,CTL(0,0,0,3),CTL(3,0,0,0)), HW, HW, Z, Z), cyc: 16'd3, bad: 1'b1, ri: 3'd2, rv: 16'd0},
    // 12: R4 JLT tests a register the sub writes
    '{prog: P(W(ADDI(1,0,2),0,0,0), W(0,SUB(2,0,1),CTL(2,1,2,3),0), HW, HW, Z, Z), cyc: 16'd3, bad: 1'b1, ri: 3'd2, rv: 16'd0},
    // 13: R5 both data slots write r3
    '{prog: P(W(ADDI(3,0,1),SUB(3,0,0),0,0), HW, Z, Z, Z, Z), cyc: 16'd2, bad: 1'b1, ri: 3'd3, rv: 16'd0},
    // 14: R4 R6 JMP in slot 1 naming a written register stays legal
    '{prog: P(W(ADDI(1,0,5),0,0,CTL(0,1,1,2)), W(ADDI(1,0,1),0,0,0), HW, Z, Z, Z), cyc: 16'd4, bad: 1'b0, ri: 3'd1, rv: 16'd5}
  };

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic load_and_run(input logic [NW-1:0][IW-1:0] prog, output bit done);
    rst = 1'b1;
    for (int i = 0; i < NW; i++) begin
      imem_we = 1'b1; imem_waddr = 8'(i); imem_wdata = prog[i];
      @(negedge clk);
    end
    imem_we = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    done = 1'b0;
    for (int n = 0; n < 300; n++) begin
      @(negedge clk);
      if (halted) begin done = 1'b1; break; end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    bit done;
    logic [15:0] cyc_at_halt;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", "halted in reset", 32'(halted), 0);
    chk("R11", "illegal in reset", 32'(illegal), 0);
    chk("R11", "cycles in reset", 32'(cycles), 0);
    chk("R11", "pc in reset", 32'(pc_o), 0);

    for (int v = 0; v < NV; v++) begin
      load_and_run(VEC[v].prog, done);
      chk($sformatf("vector %0d", v), "halted", 32'(done), 1);
      chk($sformatf("vector %0d", v), "cycles", 32'(cycles), 32'(VEC[v].cyc));
      chk($sformatf("vector %0d", v), "illegal", 32'(illegal), 32'(VEC[v].bad));
      peek_sel = VEC[v].ri;
      @(negedge clk);
      chk($sformatf("vector %0d", v), "register", 32'(peek_val), 32'(VEC[v].rv));
    end

    // R10 freeze after halt, and R12 peek latency, on the first program
    load_and_run(VEC[0].prog, done);
    cyc_at_halt = cycles;
    repeat (5) @(negedge clk);
    chk("R10", "cycles frozen", 32'(cycles), 32'(cyc_at_halt));
    chk("R10", "pc frozen at halt word", 32'(pc_o), 1);
    chk("R10", "halted stays", 32'(halted), 1);
    peek_sel = 3'd0;
    @(negedge clk);
    chk("R12", "peek r0", 32'(peek_val), 0);
    peek_sel = 3'd1;
    @(negedge clk);
    chk("R12", "peek r1 one clock later", 32'(peek_val), 5);

    // R11 reset clears registers and the one fetch cycle precedes execution
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R11", "r1 cleared by reset", 32'(peek_val), 0);
    chk("R11", "halted cleared", 32'(halted), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R11", "after fetch cycle cycles", 32'(cycles), 1);
    chk("R11", "after fetch cycle pc", 32'(pc_o), 0);
    chk("R11", "after fetch cycle r1 still 0", 32'(peek_val), 0);
    @(negedge clk);
    chk("R7", "first word prefetch advances pc", 32'(pc_o), 1);
    @(negedge clk);
    chk("R7", "r1 written by first word", 32'(peek_val), 5);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule